// File: doc/BRIEF.md
# UART Interrupt Source and Mask Controller

This block holds the four interrupt source flags of one serial channel. It builds a masked pending word from them and drives one interrupt line. The transmit and receive flags are set from the fill counts of the transmit and receive FIFOs. Each count is compared with a level that a three-bit trigger code selects. The receive flag also responds to a receive-timeout pulse. The error flag is set by overflow and read-while-empty pulses, and the modem flag by a modem event pulse.

Software reaches the source, pending and mask registers through a simple write/read port. The two clear paths behave differently:
- Writing ones to the pending register clears those bits in both the pending and source registers.
- Writing ones to the source register clears only the source bits. The pending word keeps its value until the next refresh.

The block also drives a receive-DMA busy line. It is high while the receive path is in DMA mode and the receive FIFO is empty.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Source and pending bits sit at fixed positions: receive at bit 0, error at bit 1, transmit at bit 2, modem at bit 3. The read port returns a register selected by `reg_sel_i`: 0 returns source, 1 returns pending, 2 returns mask, and 3 returns zero. The read is combinational.
- R2: A write with select 2 loads the mask. The pending word and `irq_o` reflect the new mask in the cycle after the write.
- R3: A pending bit is never set while its mask bit is set. `irq_o` is high exactly when the pending word is nonzero.
- R4: A write with select 1 clears the written one-bits in both source and pending in the next cycle. A set condition in the same cycle wins over the clear.
- R5: A write with select 0 clears the written one-bits in source only. The pending word holds its value across that cycle unless the same cycle also has a set condition.
- R6: With `fifo_en_i` high, bit 2 of source is set when `tx_count_i` is at most the transmit level. The transmit code is `fifo_ctrl_i[10:8]`.
- R7: With `fifo_en_i` high, bit 0 of source is set in either of two cases. The first is `rx_count_i` at or above the receive level, whose code is `fifo_ctrl_i[6:4]` plus one. The second is `rx_count_i` nonzero while `ctrl_i[7]` (timeout enable) is 0.
- R8: A `rx_tmo_i` pulse sets bit 0 of source when `rx_count_i` is nonzero, even with FIFOs disabled.
- R9: Bit 1 of source is set by a `rx_ovf_i` or `rx_underrun_i` pulse. Bit 3 is set by a `modem_evt_i` pulse.
- R10: `dma_busy_o` is high exactly when `ctrl_i[1:0]` equals 2 and `rx_count_i` is zero.
- R11: A trigger code c maps to the level min(c*TRIG_STEP, FIFO_DEPTH). With the defaults this is min(2c, 16).
- R12: After reset, source, pending and mask are all zero. Pending is refreshed to (source & ~mask) on any cycle with a set condition, a pending write or a mask write. On all other cycles it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode enable |
| ctrl_i | input | 8 | Channel control; [1:0] receive mode, [7] receive timeout enable |
| fifo_ctrl_i | input | 11 | FIFO control; [6:4] receive code, [10:8] transmit code |
| tx_count_i | input | CNT_W | Transmit FIFO fill count |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_ovf_i | input | 1 | Pulse: incoming data exceeded free space |
| rx_underrun_i | input | 1 | Pulse: receive FIFO read while empty |
| rx_tmo_i | input | 1 | Pulse: receive timeout expired |
| modem_evt_i | input | 1 | Pulse: modem event |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 source, 1 pending, 2 mask) |
| reg_wdata_i | input | 4 | Write data |
| reg_rdata_o | output | 4 | Read data for the selected register |
| src_o | output | 4 | Source-pending bits |
| pend_o | output | 4 | Masked pending bits |
| irq_o | output | 1 | Interrupt request |
| dma_busy_o | output | 1 | Receive DMA busy |

## Verification
Some properties are checked by assertions on every cycle:
- the pending word never overlaps the mask;
- a pending write leaves cleared bits at zero unless a set re-arms them;
- a source write leaves the pending word untouched;
- a mask write lands one cycle later;
- a transmit level hit always sets the transmit flag;
- the DMA busy line stays low while receive data is present.

Other behaviour can only be shown through the bench's scenarios. This covers the exact trigger boundaries (count equal to and one past the level, for the top codes) and the timeout pulse setting the receive flag with FIFOs off. It also covers the ordering of the source-only clear against a later pending clear, and the mixing of random events against a cycle-accurate reference.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_W = 4;
  localparam int B_RX  = 0;
  localparam int B_ERR = 1;
  localparam int B_TX  = 2;
  localparam int B_MDM = 3;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_PEND = 2'd1,
    SEL_MASK = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int FIFO_DEPTH = 16,
  parameter int TRIG_STEP  = 2,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter bit IS_RX      = 1'b0
) (
  input  logic [2:0]       code_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             hit_o
);
  localparam int LW = CNT_W + 4;

  logic [3:0]       eff_code;
  logic [LW-1:0]    raw_lvl;
  logic [CNT_W-1:0] lvl;

  assign eff_code = IS_RX ? ({1'b0, code_i} + 4'd1) : {1'b0, code_i};
  assign raw_lvl  = LW'(eff_code) * LW'(TRIG_STEP);
  assign lvl      = (raw_lvl > LW'(FIFO_DEPTH)) ? CNT_W'(FIFO_DEPTH) : raw_lvl[CNT_W-1:0];

  generate
    if (IS_RX) begin : g_rx
      assign hit_o = (count_i >= lvl);
    end else begin : g_tx
      assign hit_o = (count_i <= lvl);
    end
  endgenerate
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] set_i,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] src_o,
  output logic [SRC_W-1:0] pend_o,
  output logic [SRC_W-1:0] mask_o
);
  logic [SRC_W-1:0] src_q, pend_q, mask_q;
  logic [SRC_W-1:0] src_d, pend_d, mask_d, src_clr;
  logic             wr_src, wr_pend, wr_mask, refresh;

  assign wr_src  = we_i && (sel_i == SEL_SRC);
  assign wr_pend = we_i && (sel_i == SEL_PEND);
  assign wr_mask = we_i && (sel_i == SEL_MASK);

  // both clear paths hit source; set wins over clear
  assign src_clr = (wr_src || wr_pend) ? wdata_i : '0;
  assign src_d   = (src_q & ~src_clr) | set_i;
  assign mask_d  = wr_mask ? wdata_i : mask_q;
  // a source-only write does not refresh pending
  assign refresh = wr_pend || wr_mask || (|set_i);
  assign pend_d  = refresh ? (src_d & ~mask_d) : pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      src_q  <= src_d;
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  assign src_o  = src_q;
  assign pend_o = pend_q;
  assign mask_o = mask_q;

  p_pend_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & mask_q) == '0);

  p_pend_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_PEND) |=> ((src_q | pend_q) & $past(wdata_i & ~set_i)) == '0);

  p_src_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_SRC && set_i == '0) |=>
      ((src_q & $past(wdata_i)) == '0) && $stable(pend_q));

  p_mask_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_MASK) |=> mask_q == $past(wdata_i));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TRIG_STEP  = 2,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [7:0]       ctrl_i,
  input  logic [10:0]      fifo_ctrl_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             rx_ovf_i,
  input  logic             rx_underrun_i,
  input  logic             rx_tmo_i,
  input  logic             modem_evt_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [3:0]       reg_wdata_i,
  output logic [3:0]       reg_rdata_o,
  output logic [3:0]       src_o,
  output logic [3:0]       pend_o,
  output logic             irq_o,
  output logic             dma_busy_o
);
  logic             tx_hit, rx_hit, rx_nz;
  logic [SRC_W-1:0] set_vec, mask_q;

  uart_irq_trig #(.FIFO_DEPTH(FIFO_DEPTH), .TRIG_STEP(TRIG_STEP), .CNT_W(CNT_W), .IS_RX(1'b0))
    u_tx_trig (.code_i(fifo_ctrl_i[10:8]), .count_i(tx_count_i), .hit_o(tx_hit));

  uart_irq_trig #(.FIFO_DEPTH(FIFO_DEPTH), .TRIG_STEP(TRIG_STEP), .CNT_W(CNT_W), .IS_RX(1'b1))
    u_rx_trig (.code_i(fifo_ctrl_i[6:4]), .count_i(rx_count_i), .hit_o(rx_hit));

  assign rx_nz = (rx_count_i != '0);

  always_comb begin
    set_vec        = '0;
    set_vec[B_TX]  = fifo_en_i && tx_hit;
    set_vec[B_RX]  = (fifo_en_i && (rx_hit || (rx_nz && !ctrl_i[7]))) || (rx_tmo_i && rx_nz);
    set_vec[B_ERR] = rx_ovf_i || rx_underrun_i;
    set_vec[B_MDM] = modem_evt_i;
  end

  uart_irq_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .src_o   (src_o),
    .pend_o  (pend_o),
    .mask_o  (mask_q)
  );

  always_comb begin
    unique case (reg_sel_i)
      SEL_SRC:  reg_rdata_o = src_o;
      SEL_PEND: reg_rdata_o = pend_o;
      SEL_MASK: reg_rdata_o = mask_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o      = |pend_o;
  assign dma_busy_o = (ctrl_i[1:0] == 2'd2) && !rx_nz;

  p_tx_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && tx_hit) |=> src_o[B_TX]);

  p_dma_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_nz |-> !dma_busy_o);

  p_irq_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o == '0) |-> !irq_o);
endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
  localparam int DEPTH = 16;
  localparam int CW    = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          fifo_en_i = 1'b0;
  logic [7:0]    ctrl_i = '0;
  logic [10:0]   fifo_ctrl_i = '0;
  logic [CW-1:0] tx_count_i = '0, rx_count_i = '0;
  logic          rx_ovf_i = 1'b0, rx_underrun_i = 1'b0, rx_tmo_i = 1'b0, modem_evt_i = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [1:0]    reg_sel_i = '0;
  logic [3:0]    reg_wdata_i = '0;
  logic [3:0]    reg_rdata_o, src_o, pend_o;
  logic          irq_o, dma_busy_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [3:0] m_src = '0, m_pend = '0, m_mask = '0;

  uart_irq_ctrl uut (.*);

  always #5 clk_i = ~clk_i;

  function automatic int lvl(int code);
    return (code * 2 > DEPTH) ? DEPTH : code * 2;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge with inputs driven; steps one clock and checks state
  task automatic tick(string tag);
    logic [3:0] set_v, clr, mask_n, src_n;
    bit wp, wm;
    #1;
    chk("R10", dma_busy_o, (ctrl_i[1:0] == 2'd2) && (rx_count_i == 0));
    chk("R1", reg_rdata_o, reg_sel_i == 2'd0 ? m_src : reg_sel_i == 2'd1 ? m_pend :
                           reg_sel_i == 2'd2 ? m_mask : 4'h0);
    set_v    = '0;
    set_v[2] = fifo_en_i && (int'(tx_count_i) <= lvl(int'(fifo_ctrl_i[10:8])));
    set_v[0] = (fifo_en_i && ((int'(rx_count_i) >= lvl(int'(fifo_ctrl_i[6:4]) + 1)) ||
                (rx_count_i != 0 && !ctrl_i[7]))) || (rx_tmo_i && rx_count_i != 0);
    set_v[1] = rx_ovf_i || rx_underrun_i;
    set_v[3] = modem_evt_i;
    wp       = reg_we_i && reg_sel_i == 2'd1;
    wm       = reg_we_i && reg_sel_i == 2'd2;
    clr      = (reg_we_i && reg_sel_i <= 2'd1) ? reg_wdata_i : 4'h0;
    src_n    = (m_src & ~clr) | set_v;
    mask_n   = wm ? reg_wdata_i : m_mask;
    if (wp || wm || set_v != 0) m_pend = src_n & ~mask_n;
    m_src  = src_n;
    m_mask = mask_n;
    @(negedge clk_i);
    chk(tag, src_o, m_src);
    chk(tag, pend_o, m_pend);
    chk("R3", irq_o, |m_pend);
    reg_we_i = 1'b0; rx_ovf_i = 1'b0; rx_underrun_i = 1'b0; rx_tmo_i = 1'b0; modem_evt_i = 1'b0;
  endtask

  task automatic wr(logic [1:0] sel, logic [3:0] d);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
  endtask

  task automatic quiet_clear();
    fifo_en_i = 1'b0; rx_count_i = '0; tx_count_i = '0;
    wr(2'd1, 4'hF); tick("R4");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R12", src_o, 0); chk("R12", pend_o, 0); chk("R12", irq_o, 0);
    reg_sel_i = 2'd2; #1 chk("R12", reg_rdata_o, 0);
    @(negedge clk_i);

    // R6 transmit boundary (code 2 -> level 4)
    fifo_en_i = 1'b1; ctrl_i = 8'h80; fifo_ctrl_i = 11'h200; tx_count_i = 5'd5; tick("R6");
    chk("R6", src_o[2], 0);
    tx_count_i = 5'd4; tick("R6"); chk("R6", src_o[2], 1);
    tx_count_i = 5'd5; wr(2'd1, 4'hF); tick("R4"); chk("R4", src_o, 0); chk("R4", pend_o, 0);
    // R4 set wins over clear
    tx_count_i = 5'd4; wr(2'd1, 4'h4); tick("R4"); chk("R4", src_o[2], 1);

    // R11 top codes: transmit 7 -> 14, receive 7+1 -> 16
    quiet_clear();
    fifo_en_i = 1'b1; fifo_ctrl_i = 11'h770; tx_count_i = 5'd15; rx_count_i = 5'd15; tick("R11");
    chk("R11", src_o, 0);
    tx_count_i = 5'd14; tick("R11"); chk("R11", src_o[2], 1);
    rx_count_i = 5'd16; tick("R7"); chk("R7", src_o[0], 1);

    // R7 nonzero count with timeout disabled
    quiet_clear();
    fifo_en_i = 1'b1; fifo_ctrl_i = 11'h030; tx_count_i = 5'd16; ctrl_i = 8'h00; rx_count_i = 5'd1;
    tick("R7"); chk("R7", src_o[0], 1);

    // R8 timeout pulse with FIFOs off
    quiet_clear();
    ctrl_i = 8'h80; rx_count_i = 5'd3; tick("R8"); chk("R8", src_o[0], 0);
    rx_tmo_i = 1'b1; tick("R8"); chk("R8", src_o[0], 1);

    // R9 error and modem events
    quiet_clear();
    rx_ovf_i = 1'b1; tick("R9"); chk("R9", src_o, 4'h2);
    quiet_clear();
    rx_underrun_i = 1'b1; modem_evt_i = 1'b1; tick("R9"); chk("R9", src_o, 4'hA);

    // R2 mask write lands next cycle
    quiet_clear();
    modem_evt_i = 1'b1; tick("R2"); chk("R2", irq_o, 1);
    wr(2'd2, 4'h8); tick("R2"); chk("R2", pend_o, 0); chk("R2", irq_o, 0);
    wr(2'd2, 4'h0); tick("R2"); chk("R2", pend_o, 4'h8);

    // R5 source-only clear keeps pending
    wr(2'd0, 4'h8); tick("R5"); chk("R5", src_o, 0); chk("R5", pend_o, 4'h8);
    wr(2'd1, 4'h8); tick("R5"); chk("R5", pend_o, 0);

    // R10 DMA busy
    ctrl_i = 8'h02; rx_count_i = 5'd0; #1 chk("R10", dma_busy_o, 1);
    rx_count_i = 5'd1; #1 chk("R10", dma_busy_o, 0);
    ctrl_i = 8'h01; rx_count_i = 5'd0; #1 chk("R10", dma_busy_o, 0);
    @(negedge clk_i);

    // R1 read select 3 returns zero
    wr(2'd2, 4'h5); tick("R1");
    reg_sel_i = 2'd3; #1 chk("R1", reg_rdata_o, 0);
    reg_sel_i = 2'd2; #1 chk("R1", reg_rdata_o, 4'h5);
    @(negedge clk_i);

    // R12 random mix against the reference
    for (int i = 0; i < 3000; i++) begin
      fifo_en_i     = ($urandom % 4) != 0;
      ctrl_i        = 8'($urandom);
      fifo_ctrl_i   = 11'($urandom);
      tx_count_i    = CW'($urandom % (DEPTH + 1));
      rx_count_i    = ($urandom % 3 == 0) ? '0 : CW'($urandom % (DEPTH + 1));
      rx_ovf_i      = ($urandom % 10) == 0;
      rx_underrun_i = ($urandom % 10) == 0;
      rx_tmo_i      = ($urandom % 8) == 0;
      modem_evt_i   = ($urandom % 8) == 0;
      reg_we_i      = ($urandom % 3) == 0;
      reg_sel_i     = 2'($urandom);
      reg_wdata_i   = 4'($urandom);
      tick("R12");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule